// File: doc/BRIEF.md
# Banked Scratchpad with Conflict Serialization

This block is a multi-bank scratchpad that serves a group of 16 lanes in one request. Every lane carries its own enable, word address, write flag and write data. The block splits the word address into a bank number and a row within that bank. When two or more lanes need different rows of the same bank, the block spreads those lanes over several cycles. Lanes that point at the same word are merged, so a request in which every lane reads one word is served in a single broadcast cycle.

A request is taken while `busy` is low. From the next cycle `busy` stays high until the last group of lanes has been served, and any request offered in that time is dropped. The read results for all lanes are then shown together, `done` pulses for one cycle, and `cycles` reports how many service cycles the request used. Results and count stay on the outputs until the next request is accepted.

Top module: `smem_banked`

## Requirements
- R1: A 12-bit word address selects bank `addr[3:0]` (address modulo 16) and row `addr[11:4]`. The store has 16 banks of 256 words, each 32 bits wide.
- R2: When the enabled lanes all hit different banks, the request takes one service cycle. This covers stride 1 and any one-to-one permutation over the banks.
- R3: `cycles` equals the largest number of distinct addresses that the enabled lanes aim at any single bank. Stride 2 gives 2, stride 8 gives 8, and any odd stride gives 1.
- R4: When every enabled lane uses the same address, the request is served in one cycle, and every lane returns that word.
- R5: Accepting a request raises `busy` in the next cycle. `busy` falls together with the `done` pulse, and a request offered while `busy` is high is ignored. `done` is first seen max(`cycles`,1) cycles after the accepting edge.
- R6: `done` lasts exactly one cycle. `rd_data` and `cycles` hold their values until the next request is accepted.
- R7: A lane whose enable is low writes nothing and adds no cycles. Its `rd_data` slice reads zero.
- R8: When several enabled lanes write the same word in one request, the word takes the data of the lane with the highest index.
- R9: Every enabled lane, whether it reads or writes, returns the word's content from before the request. Writes are visible to later requests.
- R10: A request with no enabled lane completes with `cycles` = 0 and `done` one cycle after the accepting edge.
- R11: After reset, `busy`, `done`, `cycles` and `rd_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Offer a request; accepted when `busy` is low |
| req_lane_en | input | 16 | Per-lane enable |
| req_addr | input | 192 | Per-lane word address, lane i at bits [12i+11:12i] |
| req_we | input | 16 | Per-lane write flag |
| req_wdata | input | 512 | Per-lane write data, lane i at bits [32i+31:32i] |
| busy | output | 1 | Request in progress; new requests are dropped |
| done | output | 1 | One-cycle pulse when results are ready |
| rd_data | output | 512 | Per-lane read results, lane i at bits [32i+31:32i] |
| cycles | output | 5 | Service cycles used by the last request |

## Verification
The main function is driven with stride 1, a scrambled permutation, odd stride 3, stride 2 and stride 8. Together these separate a correct per-bank count of distinct words from a design that counts lanes or ignores banks. An all-same-address read and a same-word write from all lanes check that matching addresses merge into one cycle and that the highest lane wins. A half-enabled pattern, an empty request and a request offered while busy check that disabled lanes and dropped requests leave both the memory and the cycle count unchanged. A mixed read-and-write test on one word separates old-value reads from read-after-write behaviour.

// File: rtl/smem_pkg.sv
package smem_pkg;
  localparam int unsigned SMEM_LANES = 16;
  localparam int unsigned SMEM_BANKS = 16;
  localparam int unsigned SMEM_DEPTH = 256;
  localparam int unsigned SMEM_DW    = 32;
endpackage

// File: rtl/smem_bank.sv
module smem_bank #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned RW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [RW-1:0] row,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] store [DEPTH];

  // read is combinational so a bank turns one row per cycle
  assign rd_data = store[row];

  always_ff @(posedge clk) begin
    if (wr_en) store[row] <= wr_data;
  end
endmodule

// File: rtl/smem_bank_arb.sv
module smem_bank_arb #(
  parameter int unsigned LANES   = 16,
  parameter int unsigned BW      = 4,
  parameter int unsigned RW      = 8,
  parameter int unsigned DW      = 32,
  parameter int unsigned BANK_ID = 0
) (
  input  logic [LANES-1:0]         pend,
  input  logic [LANES-1:0][BW-1:0] lane_bank,
  input  logic [LANES-1:0][RW-1:0] lane_row,
  input  logic [LANES-1:0]         lane_we,
  input  logic [LANES-1:0][DW-1:0] lane_wdata,
  output logic [LANES-1:0]         serve,
  output logic [RW-1:0]            row_sel,
  output logic                     wr_en,
  output logic [DW-1:0]            wr_data
);
  localparam logic [BW-1:0] MY_BANK = BW'(BANK_ID);

  logic            found;
  logic [LANES-1:0] hit;

  always_comb begin
    for (int i = 0; i < LANES; i++) hit[i] = pend[i] && (lane_bank[i] == MY_BANK);
  end

  // lowest pending lane in this bank picks the row
  always_comb begin
    found   = 1'b0;
    row_sel = '0;
    for (int i = 0; i < LANES; i++) begin
      if (!found && hit[i]) begin
        found   = 1'b1;
        row_sel = lane_row[i];
      end
    end
  end

  // every pending lane on the same row rides along
  always_comb begin
    for (int i = 0; i < LANES; i++) serve[i] = found && hit[i] && (lane_row[i] == row_sel);
  end

  // ascending scan: the highest writing lane is last and wins
  always_comb begin
    wr_en   = 1'b0;
    wr_data = '0;
    for (int i = 0; i < LANES; i++) begin
      if (serve[i] && lane_we[i]) begin
        wr_en   = 1'b1;
        wr_data = lane_wdata[i];
      end
    end
  end
endmodule

// File: rtl/smem_banked.sv
module smem_banked
  import smem_pkg::*;
#(
  parameter int unsigned LANES = SMEM_LANES,
  parameter int unsigned BANKS = SMEM_BANKS,
  parameter int unsigned DEPTH = SMEM_DEPTH,
  parameter int unsigned DW    = SMEM_DW,
  localparam int unsigned BW   = $clog2(BANKS),
  localparam int unsigned RW   = $clog2(DEPTH),
  localparam int unsigned AW   = BW + RW,
  localparam int unsigned CW   = $clog2(LANES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [LANES-1:0]    req_lane_en,
  input  logic [LANES*AW-1:0] req_addr,
  input  logic [LANES-1:0]    req_we,
  input  logic [LANES*DW-1:0] req_wdata,
  output logic                busy,
  output logic                done,
  output logic [LANES*DW-1:0] rd_data,
  output logic [CW-1:0]       cycles
);
  // captured request
  logic [LANES*AW-1:0]       addr_q;
  logic [LANES-1:0]          we_q;
  logic [LANES-1:0][DW-1:0]  wdata_q;
  logic [LANES-1:0][BW-1:0]  lane_bank;
  logic [LANES-1:0][RW-1:0]  lane_row;

  // control state
  logic                      busy_q, busy_d;
  logic                      done_q, done_d;
  logic [LANES-1:0]          pend_q, pend_d;
  logic [CW-1:0]             cnt_q, cnt_d;
  logic [LANES-1:0][DW-1:0]  rdata_q, rdata_d;

  logic                      accept;
  logic [BANKS-1:0][LANES-1:0] serve_b;
  logic [LANES-1:0]          served;
  logic [BANKS-1:0][DW-1:0]  bank_rdata;

  assign accept = req_valid && !busy_q;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_bank[i] = addr_q[i*AW +: BW];
    assign lane_row[i]  = addr_q[i*AW+BW +: RW];
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [RW-1:0] row_sel;
    logic          wr_en;
    logic [DW-1:0] wr_data;

    smem_bank_arb #(
      .LANES(LANES), .BW(BW), .RW(RW), .DW(DW), .BANK_ID(b)
    ) i_arb (
      .pend      (pend_q),
      .lane_bank (lane_bank),
      .lane_row  (lane_row),
      .lane_we   (we_q),
      .lane_wdata(wdata_q),
      .serve     (serve_b[b]),
      .row_sel   (row_sel),
      .wr_en     (wr_en),
      .wr_data   (wr_data)
    );

    smem_bank #(.DW(DW), .DEPTH(DEPTH)) i_bank (
      .clk    (clk),
      .wr_en  (wr_en && busy_q),
      .row    (row_sel),
      .wr_data(wr_data),
      .rd_data(bank_rdata[b])
    );
  end

  always_comb begin
    served = '0;
    for (int b = 0; b < BANKS; b++) served = served | serve_b[b];
  end

  // next state
  always_comb begin
    pend_d  = pend_q;
    busy_d  = busy_q;
    done_d  = 1'b0;
    cnt_d   = cnt_q;
    rdata_d = rdata_q;
    if (accept) begin
      pend_d  = req_lane_en;
      busy_d  = 1'b1;
      cnt_d   = '0;
      rdata_d = '0;
    end else if (busy_q) begin
      pend_d = pend_q & ~served;
      if (|served) cnt_d = cnt_q + CW'(1);
      for (int i = 0; i < LANES; i++) begin
        if (served[i]) rdata_d[i] = bank_rdata[lane_bank[i]];
      end
      if (pend_d == '0) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      pend_q  <= '0;
      cnt_q   <= '0;
      rdata_q <= '0;
    end else begin
      busy_q  <= busy_d;
      done_q  <= done_d;
      pend_q  <= pend_d;
      cnt_q   <= cnt_d;
      rdata_q <= rdata_d;
    end
  end

  // request capture, enabled on accept only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      we_q    <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      we_q    <= req_we;
      wdata_q <= req_wdata;
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign cycles  = cnt_q;
  assign rd_data = rdata_q;
endmodule

// File: rtl/smem_banked_chk.sv
module smem_banked_chk #(
  parameter int unsigned LANES = 16,
  parameter int unsigned CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          busy,
  input logic          done,
  input logic [CW-1:0] cycles
);
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_excl_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  assert_done_after_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  assert_fall_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_accept_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);

  assert_cycles_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cycles <= CW'(LANES)));

  assert_count_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> $stable(cycles));
endmodule

bind smem_banked smem_banked_chk #(.LANES(LANES), .CW(CW)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .busy     (busy),
  .done     (done),
  .cycles   (cycles)
);

// File: tb/test_smem_banked.sv
`timescale 1ns/1ps
module test_smem_banked;
  localparam int L = 16, AW = 12, DW = 32, CW = 5, WORDS = 4096;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [L-1:0] req_lane_en = '0, req_we = '0;
  logic [L*AW-1:0] req_addr = '0;
  logic [L*DW-1:0] req_wdata = '0;
  logic busy, done;
  logic [L*DW-1:0] rd_data;
  logic [CW-1:0] cycles;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [DW-1:0] model [WORDS];
  logic [AW-1:0] t_addr [L];
  logic          t_en [L];
  logic          t_we [L];
  logic [DW-1:0] t_wd [L];

  always #2 clk = ~clk;

  smem_banked i_smem_banked (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lane_en(req_lane_en),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rd_data(rd_data), .cycles(cycles));

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int exp_cycles();
    int cnt [L];
    int mx = 0;
    for (int b = 0; b < L; b++) cnt[b] = 0;
    for (int i = 0; i < L; i++) begin
      bit seen = 0;
      if (!t_en[i]) continue;
      for (int j = 0; j < i; j++) if (t_en[j] && t_addr[j] == t_addr[i]) seen = 1;
      if (!seen) cnt[t_addr[i][3:0]]++;
    end
    for (int b = 0; b < L; b++) if (cnt[b] > mx) mx = cnt[b];
    return mx;
  endfunction

  function automatic logic [DW-1:0] pat(int a, int salt);
    return DW'(a) * 32'h9E37_79B1 ^ DW'(salt);
  endfunction

  task automatic clear_req();
    for (int i = 0; i < L; i++) begin
      t_addr[i] = '0; t_en[i] = 0; t_we[i] = 0; t_wd[i] = '0;
    end
  endtask

  // drive one request, wait for done, check cycles, latency and read data
  task automatic run_req(string req, bit chk_rd, int intrude);
    logic [DW-1:0] exp_rd [L];
    int ec, lat;
    ec = exp_cycles();
    for (int i = 0; i < L; i++) exp_rd[i] = t_en[i] ? model[t_addr[i]] : '0;
    @(negedge clk);
    req_valid = 1'b1;
    for (int i = 0; i < L; i++) begin
      req_lane_en[i] = t_en[i];
      req_we[i] = t_we[i];
      req_addr[i*AW +: AW] = t_addr[i];
      req_wdata[i*DW +: DW] = t_wd[i];
    end
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!done && lat < 64) begin
      if (intrude > 0 && lat == intrude) begin
        check({req, " R5 busy during service"}, DW'(busy), 1);
        req_valid = 1'b1;
        req_lane_en = '1; req_we = '1;
        for (int i = 0; i < L; i++) begin
          req_addr[i*AW +: AW] = AW'(i * 16);
          req_wdata[i*DW +: DW] = 32'hDEAD_0000 | DW'(i);
        end
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    req_valid = 1'b0;
    check({req, " R5 done latency"}, DW'(lat), DW'(ec > 1 ? ec : 1));
    check({req, " R3 cycles"}, DW'(cycles), DW'(ec));
    if (chk_rd)
      for (int i = 0; i < L; i++) check({req, " R9 lane data"}, rd_data[i*DW +: DW], exp_rd[i]);
    for (int i = 0; i < L; i++) if (t_en[i] && t_we[i]) model[t_addr[i]] = t_wd[i];
  endtask

  task automatic t_reset();
    check("R11 busy", DW'(busy), 0);
    check("R11 done", DW'(done), 0);
    check("R11 cycles", DW'(cycles), 0);
    check("R11 rd_data", DW'(|rd_data), 0);
  endtask

  task automatic t_fill();
    for (int r = 0; r < WORDS / L; r++) begin
      clear_req();
      for (int i = 0; i < L; i++) begin
        t_en[i] = 1; t_we[i] = 1; t_addr[i] = AW'(r * L + i); t_wd[i] = pat(r * L + i, 7);
      end
      run_req("R2 fill stride1", 0, 0);
    end
  endtask

  task automatic t_stride(int stride, int base, int lit, string req);
    clear_req();
    for (int i = 0; i < L; i++) begin
      t_en[i] = 1; t_addr[i] = AW'(base + stride * i);
    end
    check({req, " R3 expected count"}, DW'(exp_cycles()), DW'(lit));
    run_req(req, 1, 0);
  endtask

  task automatic t_perm();
    clear_req();
    for (int i = 0; i < L; i++) begin
      t_en[i] = 1; t_addr[i] = AW'(((i * 5 + 3) % 16) + 16 * (i * 11 % 200));
    end
    run_req("R2 permutation", 1, 0);
    check("R2 permutation one cycle", DW'(cycles), 1);
  endtask

  task automatic t_broadcast();
    clear_req();
    for (int i = 0; i < L; i++) begin t_en[i] = 1; t_addr[i] = 12'd37; end
    run_req("R4 broadcast", 1, 0);
    check("R4 broadcast one cycle", DW'(cycles), 1);
  endtask

  task automatic t_same_write();
    clear_req();
    for (int i = 0; i < L; i++) begin
      t_en[i] = 1; t_we[i] = 1; t_addr[i] = 12'd100; t_wd[i] = 32'h5A00_0000 | DW'(i);
    end
    run_req("R8 same-word write", 1, 0);
    clear_req();
    t_en[0] = 1; t_addr[0] = 12'd100;
    run_req("R8 readback", 1, 0);
    check("R8 highest lane wins", rd_data[DW-1:0], 32'h5A00_000F);
  endtask

  task automatic t_partial();
    clear_req();
    for (int i = 0; i < L; i++) begin
      t_we[i] = 1;
      if (i % 2 == 1) begin
        t_en[i] = 1; t_addr[i] = AW'(2 * i + 1024); t_wd[i] = pat(i, 99);
      end else begin
        t_addr[i] = AW'(500 + i); t_wd[i] = 32'hBAD0_0000 | DW'(i);
      end
    end
    run_req("R7 half enabled", 1, 0);
    check("R7 disabled lanes add no cycles", DW'(cycles), 2);
    check("R7 disabled lane reads zero", rd_data[2*DW +: DW], 0);
    clear_req();
    for (int i = 0; i < L; i += 2) begin t_en[i] = 1; t_addr[i] = AW'(500 + i); end
    run_req("R7 disabled lanes wrote nothing", 1, 0);
  endtask

  task automatic t_rbw();
    logic [DW-1:0] old;
    old = model[200];
    clear_req();
    t_en[0] = 1; t_we[0] = 1; t_addr[0] = 12'd200; t_wd[0] = 32'hC0FF_EE01;
    t_en[5] = 1; t_addr[5] = 12'd200;
    t_en[3] = 1; t_addr[3] = 12'd201;
    run_req("R9 read with write", 1, 0);
    check("R9 reader sees old word", rd_data[5*DW +: DW], old);
    clear_req();
    t_en[9] = 1; t_addr[9] = 12'd200;
    run_req("R9 later read", 1, 0);
    check("R9 write visible later", rd_data[9*DW +: DW], 32'hC0FF_EE01);
  endtask

  task automatic t_empty();
    clear_req();
    t_we[4] = 1; t_addr[4] = 12'd300; t_wd[4] = 32'h1111_2222;
    run_req("R10 empty request", 1, 0);
    check("R10 zero cycles", DW'(cycles), 0);
  endtask

  task automatic t_busy_ignore();
    clear_req();
    for (int i = 0; i < L; i++) begin t_en[i] = 1; t_addr[i] = AW'(8 * i + 1); end
    run_req("R5 stride8 with intruder", 1, 2);
    check("R5 count not disturbed", DW'(cycles), 8);
    clear_req();
    for (int i = 0; i < L; i++) begin t_en[i] = 1; t_addr[i] = AW'(i * 16); end
    run_req("R5 intruder wrote nothing", 1, 0);
  endtask

  task automatic t_hold();
    logic [L*DW-1:0] snap;
    logic [CW-1:0] c;
    t_stride(2, 64, 2, "R6 hold setup");
    snap = rd_data; c = cycles;
    check("R6 done one cycle", DW'(done), 1);
    @(negedge clk);
    check("R6 done dropped", DW'(done), 0);
    repeat (3) @(negedge clk);
    check("R6 cycles held", DW'(cycles), DW'(c));
    check("R6 rd_data held", DW'(rd_data == snap), 1);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_stride(1, 16, 1, "R2 stride1");
    t_stride(3, 5, 1, "R3 stride3");
    t_stride(2, 0, 2, "R3 stride2");
    t_stride(8, 3, 8, "R3 stride8");
    t_stride(16, 7, 16, "R1 same bank all rows");
    t_perm();
    t_broadcast();
    t_same_write();
    t_partial();
    t_rbw();
    t_empty();
    t_busy_ignore();
    t_hold();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule